// File: doc/BRIEF.md
# Periodic Seconds/Minutes Interrupt Generator

This block turns the one-cycle tick strobes from a real-time clock's seconds and minutes counters into an interrupt. Software sets two independent enable bits, one per period, and an output-style bit in a small control register. Whenever the fastest enabled period elapses, the block sets a sticky status bit and, in pulse style, drives a fixed-width active-low pulse on its interrupt pin.

The status bit exists so that an interrupt handler can find out which source fired. It never holds back later interrupts: a pulse is produced for each period whether or not software has cleared the bit. In level style, the interrupt pin instead stays asserted for as long as the status bit is set.

The register port has one address bit. Writes are committed on the clock edge, and the read data is a combinational view of the addressed register.

Top module: `psi_irq_gen`

## Requirements
- R1: After reset the interrupt output is high (inactive), the control register (address 0) reads 0 and the status register (address 1) reads 0.
- R2: With both enables at 0, ticks on either input leave the status bit at 0 and the interrupt output high.
- R3: With only the minute enable set (control bit 1), a minutes tick sets the status bit and starts an interrupt, and a seconds tick is ignored.
- R4: With the second enable set (control bit 0), each seconds tick sets the status bit and starts an interrupt, whatever the minute enable is, and a minutes tick alone has no effect.
- R5: Status bit 0 at address 1 reads the sticky flag. Writing address 1 with data bit 0 at 1 clears the flag, and writing it with data bit 0 at 0 leaves the flag unchanged.
- R6: An event that arrives while the flag is still set produces a new interrupt pulse.
- R7: In pulse style (control bit 2 at 1), each event drives the interrupt output low for exactly PULSE_W cycles, starting in the cycle after the tick, and the flag stays set afterwards.
- R8: An event during a pulse restarts the count, so the output stays low for PULSE_W cycles from the newest event.
- R9: In level style (control bit 2 at 0), the interrupt output is low exactly while the flag is set and goes high in the cycle after software clears it.
- R10: If a clear write and a qualifying tick land in the same cycle, the flag stays set.
- R11: The control register reads back its bits 0 to 2 as written, with all other bits 0. Writes to it take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe when the seconds counter increments |
| min_tick | input | 1 | One-cycle strobe when the minutes counter increments |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
The hardest case to reach from the ports is a software clear and a qualifying tick on the same clock edge, while a pulse from an earlier event is still counting down. The stimulus table places the clear write and the seconds tick in the same vector while the flag is set and the pulse is active. It then switches to level style before the count has expired, so the result of that collision is visible on both the status read and the interrupt pin. Restart of the pulse is forced in the same way: a second minutes tick lands one cycle before the pulse would have ended.

// File: rtl/psi_pkg.sv
package psi_pkg;
    // Bit positions inside the control register
    localparam int unsigned CTRL_SEC_BIT   = 0;
    localparam int unsigned CTRL_MIN_BIT   = 1;
    localparam int unsigned CTRL_PULSE_BIT = 2;
    localparam int unsigned CTRL_BITS      = 3;
    // Bit position of the flag inside the status register
    localparam int unsigned STAT_FLAG_BIT  = 0;
    // Register addresses
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    typedef struct packed {
        logic pulse_mode;
        logic min_en;
        logic sec_en;
    } psi_ctrl_t;
endpackage

// File: rtl/psi_ctrl_regs.sv
module psi_ctrl_regs
    import psi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CTRL_BITS-1:0] wdata,
    output psi_ctrl_t            ctrl_q
);
    typedef struct packed {
        psi_ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ctrl.sec_en     = wdata[CTRL_SEC_BIT];
            st_d.ctrl.min_en     = wdata[CTRL_MIN_BIT];
            st_d.ctrl.pulse_mode = wdata[CTRL_PULSE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;

    // R11: a write is committed on the next edge
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q.sec_en == $past(wdata[CTRL_SEC_BIT])) &&
                  (ctrl_q.min_en == $past(wdata[CTRL_MIN_BIT])));
endmodule

// File: rtl/psi_event_sel.sv
module psi_event_sel
    import psi_pkg::*;
(
    input  psi_ctrl_t ctrl,
    input  logic      sec_tick,
    input  logic      min_tick,
    output logic      evt
);
    // The fastest enabled period wins; with the second enable on, minute
    // ticks coincide with second ticks and are not looked at separately.
    always_comb begin
        if (ctrl.sec_en)      evt = sec_tick;
        else if (ctrl.min_en) evt = min_tick;
        else                  evt = 1'b0;
    end
endmodule

// File: rtl/psi_flag.sv
module psi_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag_q
);
    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt)      st_d.flag = 1'b1;  // tick takes priority over clear
        else if (clr) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;

    a_r10_tick_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && clr) |=> flag_q);
    a_r5_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag_q);
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/psi_pulse_gen.sv
module psi_pulse_gen #(
    parameter int unsigned PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic active
);
    localparam int unsigned CNT_W = $clog2(PULSE_W + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt)                 st_d.cnt = CNT_LOAD;      // restart on every event
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);

    a_r8_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (st_q.cnt == CNT_LOAD));
    a_r7_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !evt) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));
    a_r7_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !evt) |=> !active);
endmodule

// File: rtl/psi_irq_gen.sv
module psi_irq_gen
    import psi_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned PULSE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              min_tick,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n
);
    psi_ctrl_t ctrl_q;
    logic      evt;
    logic      flag_q;
    logic      pulse_active;
    logic      ctrl_wr;
    logic      flag_clr;
    logic      unused_wdata_hi;

    assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
    assign flag_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[STAT_FLAG_BIT];
    assign unused_wdata_hi = &{1'b0, reg_wdata[DATA_W-1:CTRL_BITS]};

    psi_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (reg_wdata[CTRL_BITS-1:0]),
        .ctrl_q (ctrl_q)
    );

    psi_event_sel u_sel (
        .ctrl     (ctrl_q),
        .sec_tick (sec_tick),
        .min_tick (min_tick),
        .evt      (evt)
    );

    psi_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (flag_clr),
        .flag_q (flag_q)
    );

    psi_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .active (pulse_active)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTRL_SEC_BIT]   = ctrl_q.sec_en;
            reg_rdata[CTRL_MIN_BIT]   = ctrl_q.min_en;
            reg_rdata[CTRL_PULSE_BIT] = ctrl_q.pulse_mode;
        end else begin
            reg_rdata[STAT_FLAG_BIT]  = flag_q;
        end
    end

    assign irq_n = ctrl_q.pulse_mode ? !pulse_active : !flag_q;

    a_r2_no_enable_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.sec_en && !ctrl_q.min_en && !flag_q) |=> !flag_q);
    a_r6_pulse_despite_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && flag_q) |=> pulse_active);
    a_r4_min_ignored_with_sec: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.sec_en && !sec_tick) |-> !evt);
endmodule

// File: tb/psi_irq_gen_test.sv
`timescale 1ns/1ps
module psi_irq_gen_test;
    localparam int unsigned DW = 8;
    localparam int unsigned PW = 3;
    localparam int unsigned NV = 27;

    typedef struct packed {
        logic       wr;
        logic       addr;
        logic [7:0] wdata;
        logic       sec;
        logic       mn;
        logic       exp_irq_n;
        logic [7:0] exp_rd;
        logic [7:0] req;
    } vec_t;

    // Control bits: 0 second enable, 1 minute enable, 2 pulse style.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'd2},  // R2 idle
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00, 8'd2},  // R2 ticks, no enable
        '{1'b1, 1'b0, 8'h06, 1'b0, 1'b0, 1'b1, 8'h06, 8'd11}, // R11 min + pulse
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'd3},  // R3 sec ignored
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01, 8'd3},  // R3 min event
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'd7},  // R7
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'd7},  // R7
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 8'd7},  // R7 ends, flag kept
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01, 8'd6},  // R6 flag still set
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'd8},  // R8
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h01, 8'd8},  // R8 restart
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'd8},  // R8
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'd8},  // R8 still low
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 8'd8},  // R8 ends
        '{1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 8'd5},  // R5 write 0 no clear
        '{1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 8'h00, 8'd5},  // R5 clear
        '{1'b1, 1'b0, 8'h05, 1'b0, 1'b0, 1'b1, 8'h05, 8'd11}, // R11 sec + pulse
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'd4},  // R4 min alone ignored
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h01, 8'd4},  // R4 sec event
        '{1'b1, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 8'h01, 8'd10}, // R10 clear + tick
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'd10}, // R10
        '{1'b1, 1'b0, 8'hF9, 1'b0, 1'b0, 1'b0, 8'h01, 8'd9},  // R9 level, upper bits dropped
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'd9},  // R9 low while flag
        '{1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 8'h00, 8'd9},  // R9 cleared
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'd9},  // R9
        '{1'b1, 1'b0, 8'h03, 1'b0, 1'b0, 1'b1, 8'h03, 8'd11}, // R11 both, level
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'h01, 8'd4}   // R4 both ticks
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sec_tick = 1'b0;
    logic          min_tick = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;  // 125 MHz

    psi_irq_gen #(.DATA_W(DW), .PULSE_W(PW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_tick  (sec_tick),
        .min_tick  (min_tick),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    task automatic check(input int req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        reg_wr    = v.wr;
        reg_addr  = v.addr;
        reg_wdata = v.wdata;
        sec_tick  = v.sec;
        min_tick  = v.mn;
    endtask

    task automatic idle();
        reg_wr = 1'b0; sec_tick = 1'b0; min_tick = 1'b0; reg_wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(1, "irq_n in reset", int'(irq_n), 1);
        reg_addr = 1'b0; #1;
        check(1, "ctrl in reset", int'(reg_rdata), 0);
        rst_n = 1'b1;
        @(negedge clk);
        reg_addr = 1'b1; #1;
        check(1, "status after reset", int'(reg_rdata), 0);
        check(1, "irq_n after reset", int'(irq_n), 1);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check(int'(VECS[i].req), $sformatf("vec %0d irq_n", i), int'(irq_n), int'(VECS[i].exp_irq_n));
            check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), int'(reg_rdata), int'(VECS[i].exp_rd));
        end
        idle();

        // R1: reset in the middle of activity (flag set, level mode on)
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, "irq_n after mid reset", int'(irq_n), 1);
        reg_addr = 1'b1; #1;
        check(1, "status after mid reset", int'(reg_rdata), 0);
        reg_addr = 1'b0; #1;
        check(1, "ctrl after mid reset", int'(reg_rdata), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: pulse width directed, second enable + pulse style
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h05;
        @(negedge clk);
        idle(); sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        for (int k = 0; k < int'(PW); k++) begin
            check(7, $sformatf("pulse cycle %0d", k), int'(irq_n), 0);
            @(negedge clk);
        end
        check(7, "pulse over", int'(irq_n), 1);
        reg_addr = 1'b1; #1;
        check(7, "flag kept after pulse", int'(reg_rdata), 1);

        finish_run();
    end
endmodule